// File: doc/BRIEF.md
# Opcode-Armed Video-RAM Select Strobe

This block sits beside a CPU bus. It watches opcode-fetch cycles for one bit pattern in the fetched byte. When it sees that pattern while no interrupt is pending, it arms a short delay. A fixed number of CPU cycles later it raises a select strobe for exactly one cycle. In that cycle the surrounding logic skips its normal address decoding and sends the access, whether a read or a write, to the video-RAM path instead. The strobe is timed to land on the indirect data access of the triggering instruction, so the pointer reads in between are left alone.

The block has no data stream. All of its pins are plain control and status signals with no handshake. Inputs are sampled on the rising clock edge. The strobe and the decode-enable outputs come from the delay counter alone, so they are free of combinational paths from the inputs. The current value of the delay counter is brought out so that the system can observe it.

Top module: `vram_redirect_detector`

## Requirements
- R1: While reset is active and after it is released, `delay_count` is 0, `redirect_sel` is 0 and `normal_decode_en` is 1.
- R2: A qualifying fetch arms the block. A qualifying fetch is a rising edge with `fetch_sync`=1, `irq_pending`=0 and `rd_data[4:0]`=5'b00001. In the cycle after that edge, `delay_count` reads 5.
- R3: `redirect_sel` is high for exactly one cycle, the fifth cycle after the qualifying fetch cycle, in which `delay_count` reads 1. It is low in every other cycle.
- R4: A fetch with the matching pattern while `irq_pending`=1 does not arm the block: `delay_count` stays 0 and no strobe follows.
- R5: A matching byte on `rd_data` with `fetch_sync`=0 does not arm the block.
- R6: Only `rd_data[4:0]` is compared. `rd_data[7:5]` is ignored, so 8'hE1 arms the block, while 8'h03, 8'h11 and 8'h00 do not.
- R7: The edge that ends the strobe cycle clears the armed state (`delay_count` becomes 0). No further strobe occurs until a new qualifying fetch.
- R8: A qualifying fetch while the block is already armed reloads `delay_count` to 5. The strobe then comes five cycles after the newer fetch and does not come at the time set by the older one.
- R9: `normal_decode_en` is low exactly in the cycles where `redirect_sel` is high.
- R10: While armed and not reloaded, `delay_count` decreases by one on each rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_sync | input | 1 | High during an opcode-fetch cycle |
| rd_data | input | 8 | CPU read data bus |
| irq_pending | input | 1 | Interrupt request currently asserted |
| redirect_sel | output | 1 | One-cycle strobe that routes the access to video RAM |
| normal_decode_en | output | 1 | Normal address decoding allowed (low during the strobe) |
| delay_count | output | 3 | Cycles remaining until the strobe (0 = idle) |

## Verification
The bench checks the strobe cycle by cycle. A design that is off by one in the delay would raise the strobe one cycle early or late, and the bench would report it. It sends near-miss bytes (8'h03, 8'h11), a byte that differs only in the ignored high bits (8'hE1), a match with the interrupt pending, and a match with the fetch indicator low. A decoder that compares the wrong bits, or that ignores the interrupt or the fetch qualifier, would arm the block in one of these cases. A second fetch arrives partway through a countdown: a design that does not reload the counter would fire on the older schedule. After each strobe the bench idles for several cycles to catch a design that never clears its armed state and fires again.

// File: rtl/vrd_pkg.sv
package vrd_pkg;
  // Counter width able to hold the delay value itself.
  function automatic int cnt_width(input int delay);
    return (delay < 2) ? 1 : $clog2(delay + 1);
  endfunction
endpackage

// File: rtl/vrd_opcode_match.sv
module vrd_opcode_match #(
  parameter int DATA_W = 8,
  parameter int MATCH_W = 5,
  parameter logic [MATCH_W-1:0] MATCH_VAL = 5'b00001
) (
  input  logic              fetch_sync,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              irq_pending,
  output logic              qualify
);
  logic pattern_hit;

  assign pattern_hit = (rd_data[MATCH_W-1:0] == MATCH_VAL);
  assign qualify     = fetch_sync && !irq_pending && pattern_hit;

  generate
    if (DATA_W > MATCH_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^rd_data[DATA_W-1:MATCH_W];
    end
  endgenerate
endmodule

// File: rtl/vrd_countdown.sv
module vrd_countdown #(
  parameter int DELAY = 5,
  parameter int CW = vrd_pkg::cnt_width(DELAY)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  output logic [CW-1:0] count,
  output logic          expire
);
  localparam logic [CW-1:0] LOAD_VAL = CW'(DELAY);
  localparam logic [CW-1:0] LAST_VAL = CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (load)
      count <= LOAD_VAL;
    else if (count != '0)
      count <= count - LAST_VAL;
  end

  assign expire = (count == LAST_VAL);
endmodule

// File: rtl/vram_redirect_detector.sv
module vram_redirect_detector #(
  parameter int DATA_W = 8,
  parameter int MATCH_W = 5,
  parameter logic [MATCH_W-1:0] MATCH_VAL = 5'b00001,
  parameter int DELAY = 5,
  localparam int CW = vrd_pkg::cnt_width(DELAY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_sync,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              irq_pending,
  output logic              redirect_sel,
  output logic              normal_decode_en,
  output logic [CW-1:0]     delay_count
);
  logic arm;
  logic fire;

  vrd_opcode_match #(
    .DATA_W(DATA_W), .MATCH_W(MATCH_W), .MATCH_VAL(MATCH_VAL)
  ) u_match (
    .fetch_sync(fetch_sync),
    .rd_data(rd_data),
    .irq_pending(irq_pending),
    .qualify(arm)
  );

  vrd_countdown #(.DELAY(DELAY), .CW(CW)) u_cnt (
    .clk(clk),
    .rst_n(rst_n),
    .load(arm),
    .count(delay_count),
    .expire(fire)
  );

  assign redirect_sel     = fire;
  assign normal_decode_en = !fire;
endmodule

// File: rtl/vrd_checker.sv
module vrd_checker #(
  parameter int DATA_W = 8,
  parameter int MATCH_W = 5,
  parameter logic [MATCH_W-1:0] MATCH_VAL = 5'b00001,
  parameter int DELAY = 5,
  parameter int CW = vrd_pkg::cnt_width(DELAY)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_sync,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_pending,
  input logic              redirect_sel,
  input logic [CW-1:0]     delay_count
);
  localparam int SW = $clog2(DELAY + 2);

  logic          qual;
  logic          seen;
  logic [SW-1:0] since;

  assign qual = fetch_sync && !irq_pending && (rd_data[MATCH_W-1:0] == MATCH_VAL);

  // Cycles elapsed since the latest qualifying fetch, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      since <= '0;
    end else if (qual) begin
      seen  <= 1'b1;
      since <= SW'(1);
    end else if (seen && since != '1) begin
      since <= since + SW'(1);
    end
  end

  assert_arm_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> delay_count == CW'(DELAY));

  assert_strobe_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_sel |-> (seen && since == SW'(DELAY)));

  assert_irq_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_sync && irq_pending && delay_count == '0) |=> delay_count == '0);

  assert_clear_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_sel && !qual) |=> (delay_count == '0 && !redirect_sel));

  assert_step_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_count > CW'(1) && !qual) |=> delay_count == $past(delay_count) - CW'(1));

  generate
    if (DELAY > 1) begin : g_pulse
      assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_sel |=> !redirect_sel);
    end
  endgenerate
endmodule

bind vram_redirect_detector vrd_checker #(
  .DATA_W(DATA_W), .MATCH_W(MATCH_W), .MATCH_VAL(MATCH_VAL), .DELAY(DELAY), .CW(CW)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .fetch_sync(fetch_sync),
  .rd_data(rd_data),
  .irq_pending(irq_pending),
  .redirect_sel(redirect_sel),
  .delay_count(delay_count)
);

// File: tb/vram_redirect_detector_test.sv
`timescale 1ns/1ps
module vram_redirect_detector_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fetch_sync = 1'b0;
  logic [7:0] rd_data = 8'hFF;
  logic       irq_pending = 1'b0;
  logic       redirect_sel;
  logic       normal_decode_en;
  logic [2:0] delay_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vram_redirect_detector uut (
    .clk(clk), .rst_n(rst_n), .fetch_sync(fetch_sync), .rd_data(rd_data),
    .irq_pending(irq_pending), .redirect_sel(redirect_sel),
    .normal_decode_en(normal_decode_en), .delay_count(delay_count)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  // Expected outputs from a known remaining count.
  task automatic check_state(input string req, input int exp_cnt);
    check({req, " count"}, delay_count, exp_cnt);
    check({req, " strobe"}, redirect_sel, exp_cnt == 1);
    check({req, " R9 decode_en"}, normal_decode_en, exp_cnt != 1);
  endtask

  // One fetch cycle: drive at a falling edge, captured on the next rising edge.
  task automatic do_fetch(input logic sync, input logic [7:0] d, input logic irq);
    @(negedge clk);
    fetch_sync = sync; rd_data = d; irq_pending = irq;
    @(negedge clk);
    fetch_sync = 1'b0; rd_data = 8'h01; irq_pending = 1'b0;
  endtask

  task automatic idle_check(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_state(req, 0);
    end
  endtask

  task automatic t_reset;
    check_state("R1 during reset", 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after reset", 0);
  endtask

  task automatic t_basic;
    do_fetch(1'b1, 8'h01, 1'b0);
    check_state("R2 armed", 5);
    for (int c = 4; c >= 1; c--) begin
      @(negedge clk);
      check_state((c == 1) ? "R3 strobe cycle" : "R10 countdown", c);
    end
    idle_check("R7 cleared", 8);
  endtask

  task automatic t_irq;
    do_fetch(1'b1, 8'h01, 1'b1);
    check_state("R4 irq blocks", 0);
    idle_check("R4 no strobe", 6);
  endtask

  task automatic t_nosync;
    do_fetch(1'b0, 8'h01, 1'b0);
    check_state("R5 no sync", 0);
    idle_check("R5 no strobe", 6);
  endtask

  task automatic t_pattern;
    do_fetch(1'b1, 8'h03, 1'b0);
    check_state("R6 0x03", 0);
    do_fetch(1'b1, 8'h11, 1'b0);
    check_state("R6 0x11", 0);
    do_fetch(1'b1, 8'h00, 1'b0);
    check_state("R6 0x00", 0);
    idle_check("R6 no strobe", 6);
    do_fetch(1'b1, 8'hE1, 1'b0);
    check_state("R6 0xE1 arms", 5);
    for (int c = 4; c >= 1; c--) begin
      @(negedge clk);
      check_state("R6 countdown", c);
    end
    idle_check("R7 after 0xE1", 3);
  endtask

  task automatic t_retrigger;
    do_fetch(1'b1, 8'h01, 1'b0);
    check_state("R8 first arm", 5);
    @(negedge clk); check_state("R8 first step", 4);
    do_fetch(1'b1, 8'h21, 1'b0);
    check_state("R8 reloaded", 5);
    for (int c = 4; c >= 1; c--) begin
      @(negedge clk);
      check_state("R8 new schedule", c);
    end
    idle_check("R8 single strobe", 5);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_irq();
    t_nosync();
    t_pattern();
    t_retrigger();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule